// File: doc/BRIEF.md
# Big-Endian Load/Store Data Aligner

This block sits between a 32-bit load/store unit and a word-organised data memory. A request carries a byte address, an access size (byte, halfword or word), a zero-extend flag for narrow loads, and the source register value for stores. On the request cycle the block turns the byte address into a word address and, for stores, computes per-byte write enables and a write word in which the stored item has been copied into the byte lanes it will land in. Only the low 8 or 16 bits of the source register are stored for narrow accesses.

Loads are split over two cycles. The memory is assumed to return its word one cycle after the request. The block records the byte offset, size and extension mode of every accepted load. In the following cycle it selects the addressed byte or halfword from the returned word and sign-extends or zero-extends it to 32 bits. Byte lanes are big-endian: the lowest address in a word holds bits 31:24. Requests that break their alignment rule raise a misalignment flag, write nothing and return no load data.

Top module: `be_align_top`

## Requirements
- R1: `mem_addr` always equals `req_addr` with its two low bits removed.
- R2: A valid byte store at byte offset k (k = `req_addr[1:0]`) sets only `mem_we` bit 3-k, and `mem_wdata` holds `req_wdata[7:0]` in all four lanes.
- R3: A valid halfword store at offset 0 sets `mem_we` = 4'b1100, at offset 2 sets 4'b0011, and `mem_wdata` holds `req_wdata[15:0]` in both halves.
- R4: A valid word store at offset 0 sets `mem_we` = 4'b1111 and `mem_wdata` = `req_wdata`.
- R5: `misaligned` is 1 in the request cycle when `req_valid` is 1 and the access is a halfword with `req_addr[0]` = 1, a word with `req_addr[1:0]` not 0, or uses the reserved size code 2'b11. It is 0 otherwise, and whenever it is 1 `mem_we` is 4'b0000.
- R6: `mem_we` is 4'b0000 when `req_valid` is 0 or `req_write` is 0.
- R7: `load_valid` is 1 in the cycle after a valid, aligned load request (`req_valid`=1, `req_write`=0) and 0 in every other cycle. A misaligned load produces no `load_valid`.
- R8: A signed byte or halfword load (`req_unsigned`=0) replicates the item's top bit into the upper bits of `load_data`. The byte at offset k is `mem_rdata` bits [31-8k : 24-8k]; the halfword at offset 0 is bits 31:16 and at offset 2 bits 15:0.
- R9: An unsigned byte or halfword load (`req_unsigned`=1) fills the upper bits of `load_data` with zeros.
- R10: A word load returns `mem_rdata` unchanged in `load_data`.
- R11: `load_data` is 0 whenever `load_valid` is 0.
- R12: While `rst` is 1, and on the first cycle after it falls, `load_valid` is 0. Size codes are 2'b00 byte, 2'b01 halfword, 2'b10 word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_unsigned | input | 1 | Zero-extend narrow loads when 1 |
| req_wdata | input | 32 | Source register value for stores |
| mem_rdata | input | 32 | Word returned by memory, one cycle after a load request |
| mem_addr | output | ADDR_W-2 | Word address to memory |
| mem_we | output | 4 | Per-byte write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-positioned store data |
| misaligned | output | 1 | Request breaks its alignment rule |
| load_valid | output | 1 | `load_data` carries a completed load |
| load_data | output | 32 | Extended load result |

## Verification
The store path and the load return path can be active in the same cycle. A store or a new load can be issued in the very cycle the word for the previous load comes back. The bench provokes this by following loads with a store or a further load and no idle cycle between them. In that cycle it judges the write enables and write word of the new request, and the extended result of the old load, against a model that keeps the outstanding load in a queue. A misaligned load placed directly before a good one shows that the flag cancels only the request it belongs to.

// File: rtl/be_align_pkg.sv
package be_align_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LANES  = 4;
    localparam int unsigned WORD_W = BYTE_W * LANES;
    localparam int unsigned OFS_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [OFS_W-1:0] ofs;
        acc_size_e        size;
        logic             zext;
    } ld_ctx_t;

    // Alignment rule per access size.
    function automatic logic align_ok(acc_size_e sz, logic [OFS_W-1:0] ofs);
        case (sz)
            SZ_BYTE: return 1'b1;
            SZ_HALF: return ~ofs[0];
            SZ_WORD: return (ofs == '0);
            default: return 1'b0;
        endcase
    endfunction

    // Big-endian lane mask: offset 0 is lane 3 (bits 31:24).
    function automatic logic [LANES-1:0] lane_mask(acc_size_e sz, logic [OFS_W-1:0] ofs);
        case (sz)
            SZ_BYTE: return LANES'(4'b1000 >> ofs);
            SZ_HALF: return ofs[1] ? LANES'(4'b0011) : LANES'(4'b1100);
            SZ_WORD: return '1;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/be_req_check.sv
module be_req_check
    import be_align_pkg::*;
(
    input  logic             valid,
    input  acc_size_e        size,
    input  logic [OFS_W-1:0] ofs,
    output logic             bad
);
    always_comb begin
        bad = valid & ~align_ok(size, ofs);
    end
endmodule

// File: rtl/be_store_lanes.sv
module be_store_lanes
    import be_align_pkg::*;
(
    input  logic              active,
    input  acc_size_e         size,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [WORD_W-1:0] src,
    output logic [LANES-1:0]  we,
    output logic [WORD_W-1:0] wdata
);
    always_comb begin
        we = active ? lane_mask(size, ofs) : '0;
    end

    // Each lane picks the source byte it would carry for every size,
    // so the item appears in whichever lanes are enabled.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        always_comb begin
            case (size)
                SZ_BYTE: wdata[ln*BYTE_W +: BYTE_W] = src[BYTE_W-1:0];
                SZ_HALF: wdata[ln*BYTE_W +: BYTE_W] = src[(ln % 2)*BYTE_W +: BYTE_W];
                default: wdata[ln*BYTE_W +: BYTE_W] = src[ln*BYTE_W +: BYTE_W];
            endcase
        end
    end
endmodule

// File: rtl/be_load_extract.sv
module be_load_extract
    import be_align_pkg::*;
(
    input  logic              en,
    input  ld_ctx_t           ctx,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] result
);
    localparam int unsigned HALF_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] pick_b;
    logic [HALF_W-1:0] pick_h;
    logic              fill;

    always_comb begin
        pick_b = rdata[(LANES - 1 - int'(ctx.ofs)) * BYTE_W +: BYTE_W];
        pick_h = ctx.ofs[1] ? rdata[HALF_W-1:0] : rdata[WORD_W-1:HALF_W];
        result = '0;
        fill   = 1'b0;
        if (en) begin
            case (ctx.size)
                SZ_BYTE: begin
                    fill   = ~ctx.zext & pick_b[BYTE_W-1];
                    result = {{(WORD_W-BYTE_W){fill}}, pick_b};
                end
                SZ_HALF: begin
                    fill   = ~ctx.zext & pick_h[HALF_W-1];
                    result = {{(WORD_W-HALF_W){fill}}, pick_h};
                end
                default: result = rdata;
            endcase
        end
    end
endmodule

// File: rtl/be_align_top.sv
module be_align_top
    import be_align_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [31:0]       req_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [3:0]        mem_we,
    output logic [31:0]       mem_wdata,
    output logic              misaligned,
    output logic              load_valid,
    output logic [31:0]       load_data
);
    acc_size_e        size_e;
    logic [OFS_W-1:0] ofs;
    logic             bad;
    logic             st_go;
    logic             ld_go;
    ld_ctx_t          ctx_q;
    logic             ld_valid_q;

    always_comb begin
        size_e     = acc_size_e'(req_size);
        ofs        = req_addr[OFS_W-1:0];
        mem_addr   = req_addr[ADDR_W-1:OFS_W];
        misaligned = bad;
        st_go      = req_valid & req_write & ~bad;
        ld_go      = req_valid & ~req_write & ~bad;
    end

    be_req_check u_check (
        .valid (req_valid),
        .size  (size_e),
        .ofs   (ofs),
        .bad   (bad)
    );

    be_store_lanes u_store (
        .active (st_go),
        .size   (size_e),
        .ofs    (ofs),
        .src    (req_wdata),
        .we     (mem_we),
        .wdata  (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_valid_q <= 1'b0;
            ctx_q      <= '{ofs: '0, size: SZ_WORD, zext: 1'b0};
        end else begin
            ld_valid_q <= ld_go;
            if (ld_go) begin
                ctx_q <= '{ofs: ofs, size: size_e, zext: req_unsigned};
            end
        end
    end

    be_load_extract u_load (
        .en     (ld_valid_q),
        .ctx    (ctx_q),
        .rdata  (mem_rdata),
        .result (load_data)
    );

    assign load_valid = ld_valid_q;

endmodule

// File: rtl/be_align_chk.sv
module be_align_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic [3:0]        mem_we,
    input logic              misaligned,
    input logic              load_valid,
    input logic [31:0]       load_data
);
    // R5: a flagged request never writes
    a_r5_flag_blocks_write: assert property (@(posedge clk) disable iff (rst)
        misaligned |-> (mem_we == 4'b0000));

    // R5: reserved size always flagged when valid
    a_r5_reserved_flagged: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'b11) |-> misaligned);

    // R6: loads and idle cycles leave memory untouched
    a_r6_no_write_on_load: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || !req_write) |-> (mem_we == 4'b0000));

    // R2: a byte store enables exactly one lane
    a_r2_single_lane: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_size == 2'b00) |-> ($countones(mem_we) == 1));

    // R4: aligned word store enables all lanes
    a_r4_full_word: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_size == 2'b10 && req_addr[1:0] == 2'b00)
            |-> (mem_we == 4'b1111));

    // R7: a good load is answered on the next cycle
    a_r7_load_answered: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !misaligned) |=> load_valid);

    // R7: a flagged load is never answered
    a_r7_bad_load_silent: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && misaligned) |=> !load_valid);

    // R11: result is quiet without a completed load
    a_r11_quiet_result: assert property (@(posedge clk) disable iff (rst)
        !load_valid |-> (load_data == 32'h0));
endmodule

bind be_align_top be_align_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .mem_we     (mem_we),
    .misaligned (misaligned),
    .load_valid (load_valid),
    .load_data  (load_data)
);

// File: tb/be_align_top_tb_top.sv
`timescale 1ns/1ps
module be_align_top_tb_top;
    localparam int unsigned AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'b00;
    logic          req_unsigned = 1'b0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   mem_rdata = '0;
    logic [AW-3:0] mem_addr;
    logic [3:0]    mem_we;
    logic [31:0]   mem_wdata;
    logic          misaligned;
    logic          load_valid;
    logic [31:0]   load_data;

    int checks = 0;
    int fails  = 0;

    typedef struct { int ofs; int size; bit uns; } pend_t;
    pend_t pend_q[$];

    always #2.5 clk = ~clk;

    be_align_top #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_wdata(req_wdata),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .misaligned(misaligned),
        .load_valid(load_valid), .load_data(load_data)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit model_bad(bit v, int sz, int ofs);
        if (!v) return 0;
        if (sz == 3) return 1;
        if (sz == 1) return (ofs % 2) != 0;
        if (sz == 2) return ofs != 0;
        return 0;
    endfunction

    function automatic logic [3:0] model_we(int sz, int ofs);
        logic [3:0] m = '0;
        int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        for (int k = 0; k < 4; k++)
            if (k >= ofs && k < ofs + n) m[3-k] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] model_wd(int sz, logic [31:0] s);
        if (sz == 0) return {4{s[7:0]}};
        if (sz == 1) return {2{s[15:0]}};
        return s;
    endfunction

    function automatic logic [31:0] model_ld(pend_t p, logic [31:0] rd);
        logic [31:0] sh = rd << (8 * p.ofs);
        logic [7:0]  b  = sh[31:24];
        logic [15:0] h  = sh[31:16];
        if (p.size == 0) return p.uns ? {24'h0, b} : 32'($signed(b));
        if (p.size == 1) return p.uns ? {16'h0, h} : 32'($signed(h));
        return rd;
    endfunction

    // One clock: drive the request and the memory word for the previous load,
    // then judge every output against the model before the next edge.
    task automatic cyc(bit v, bit w, logic [31:0] a, int sz, bit uns,
                       logic [31:0] wd, logic [31:0] rd);
        bit          bad;
        pend_t       p;
        bit          have;
        logic [3:0]  ewe;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_size = 2'(sz);
        req_unsigned = uns; req_wdata = wd; mem_rdata = rd;
        #1;
        bad = model_bad(v, sz, a[1:0]);
        check("R1 mem_addr", 64'(mem_addr), 64'(a[31:2]));
        check("R5 misaligned", 64'(misaligned), 64'(bad));
        ewe = (v && w && !bad) ? model_we(sz, a[1:0]) : 4'b0000;
        check((v && w) ? (bad ? "R5 we" : (sz == 0 ? "R2 we" : sz == 1 ? "R3 we" : "R4 we"))
              : "R6 we", 64'(mem_we), 64'(ewe));
        if (ewe != 0)
            check(sz == 0 ? "R2 wdata" : sz == 1 ? "R3 wdata" : "R4 wdata",
                  64'(mem_wdata), 64'(model_wd(sz, wd)));
        have = pend_q.size() > 0;
        if (have) p = pend_q.pop_front();
        check("R7 load_valid", 64'(load_valid), 64'(have));
        if (have)
            check(p.size == 2 ? "R10 word load" : p.uns ? "R9 zero extend" : "R8 sign extend",
                  64'(load_data), 64'(model_ld(p, rd)));
        else
            check("R11 idle load_data", 64'(load_data), 64'h0);
        if (v && !w && !bad) pend_q.push_back('{ofs: int'(a[1:0]), size: sz, uns: uns});
    endtask

    initial begin
        #(200000 * 5);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12 reset load_valid", 64'(load_valid), 64'h0);
        check("R11 reset load_data", 64'(load_data), 64'h0);
        rst = 1'b0;
        cyc(0, 0, 32'h0, 0, 0, 0, 32'hFFFF_FFFF);   // R12 first cycle after reset

        // R4 word store, R1 addressing
        cyc(1, 1, 32'h0000_0100, 2, 0, 32'hA1B2_C3D4, 0);
        // R2 byte stores at every offset
        for (int k = 0; k < 4; k++) cyc(1, 1, 32'h0000_0200 + k, 0, 0, 32'h1234_5600 + k, 0);
        // R3 halfword stores
        cyc(1, 1, 32'h0000_0300, 1, 0, 32'hDEAD_BEEF, 0);
        cyc(1, 1, 32'h0000_0302, 1, 0, 32'hCAFE_F00D, 0);
        // R5 misaligned stores and reserved size
        cyc(1, 1, 32'h0000_0401, 1, 0, 32'h1111_2222, 0);
        cyc(1, 1, 32'h0000_0403, 1, 0, 32'h1111_2222, 0);
        for (int k = 1; k < 4; k++) cyc(1, 1, 32'h0000_0500 + k, 2, 0, 32'h3333_4444, 0);
        cyc(1, 1, 32'h0000_0600, 3, 0, 32'h5555_6666, 0);
        // R6 idle with write high
        cyc(0, 1, 32'h0000_0700, 2, 0, 32'h7777_8888, 0);

        // R8/R9 byte loads, each answered while the next request issues
        for (int u = 0; u < 2; u++)
            for (int k = 0; k < 4; k++)
                cyc(1, 0, 32'h0000_0800 + k, 0, u[0], 0, 32'h807F_FF01);
        // R8/R9 halfword loads
        cyc(1, 0, 32'h0000_0900, 1, 0, 0, 32'h807F_FF01);
        cyc(1, 0, 32'h0000_0902, 1, 0, 0, 32'h807F_FF01);
        cyc(1, 0, 32'h0000_0900, 1, 1, 0, 32'h807F_FF01);
        cyc(1, 0, 32'h0000_0902, 1, 1, 0, 32'h7F00_8001);
        // R10 word load, then a store in the return cycle
        cyc(1, 0, 32'h0000_0A00, 2, 1, 0, 32'h7F00_8001);
        cyc(1, 1, 32'h0000_0B01, 0, 0, 32'h0000_00A5, 32'h89AB_CDEF);
        // R7 misaligned load followed by a good load
        cyc(1, 0, 32'h0000_0C02, 2, 0, 0, 32'h0);
        cyc(1, 0, 32'h0000_0C03, 0, 0, 0, 32'h0);
        cyc(1, 1, 32'h0000_0D02, 1, 0, 32'h0000_BEEF, 32'h0102_0380);
        cyc(0, 0, 32'h0, 0, 0, 0, 32'hFFFF_FFFF);
        cyc(0, 0, 32'h0, 0, 0, 0, 32'hFFFF_FFFF);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule